// File: doc/BRIEF.md
# Embedded Chip Erase Sequencer with Status Polling

This block runs a complete automatic chip erase over a small memory array that sits outside it on a plain address/write-data/read-data port. A single start pulse from the command decoder is enough. The host does not have to pre-program anything. First the sequencer writes 00h to every location and reads each one back. It then issues self-timed erase pulses and checks after each pulse whether the whole array reads FFh. It stops on the first fully erased pass. If a location will not take 00h after a few writes, or the array is still not erased after a set number of pulses, the operation fails.

While the operation runs, a host read returns a status byte in place of array data. Bit 7 stays 0 until the operation is over. Bit 6 flips on every read strobe. Bit 5 reports a failure. Once the sequence finishes, the block goes back to array read mode by itself. The erased array then reads FFh, so the host sees bit 7 at 1 and bit 6 steady across two reads. After a failure the block waits in the status state, and only the abort command brings it back to read mode.

Top module: `chip_erase_engine`

## Requirements
- R1: When `busy` is low, `memAddr` follows `hostAddr` and `dataOut` equals `memRdata`; `rdStrobe` has no effect on the value returned.
- R2: `busy` rises the cycle after `startCmd`; every location is written with 00h and read back as 00h before the first erase pulse, and no other value is ever written.
- R3: While `busy` is high, `dataOut` is a status byte: bit 7 = 0, bit 5 = failure flag, bits 4..0 = 0.
- R4: While `busy` is high, status bit 6 takes the opposite value after each `rdStrobe` cycle.
- R5: When all locations read FFh after an erase pulse, `busy` falls and the block returns to array read; repeated reads then give FFh with bit 6 unchanged.
- R6: Each erase pulse holds `erasePulse` high for exactly PULSE_CYC cycles; pulses stop as soon as the array verifies erased.
- R7: If the array is not erased after MAX_PULSES pulses, status bit 5 becomes 1, no further pulse or write is issued, and `busy` stays high.
- R8: After a failure, `startCmd` is ignored (the status keeps bit 5 = 1 and nothing is written or pulsed); `abortCmd` drops `busy` and restores array read.
- R9: A location that fails its 00h read-back is rewritten; after MAX_RETRY writes in total to that location the operation fails with bit 5 = 1 and no erase pulse.
- R10: `abortCmd` during an operation drops `busy` the next cycle and stops all writes and pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | One-cycle request to begin chip erase |
| abortCmd | input | 1 | One-cycle abort / return-to-read command |
| hostAddr | input | ADDR_W | Host read address in array read mode |
| rdStrobe | input | 1 | Host read cycle marker |
| dataOut | output | 8 | Array data or status byte |
| busy | output | 1 | High from start until success or abort |
| memAddr | output | ADDR_W | Array address |
| memWe | output | 1 | Array write enable |
| memWdata | output | 8 | Array write data |
| memRdata | input | 8 | Array read data (combinational) |
| erasePulse | output | 1 | Erase pulse to the array |

## Verification
A wrong phase state shows up at the array port within one cycle: a stray write, a pulse that starts before the zero pass is done, or a pulse of the wrong length. A wrong retry or pulse counter shows up as a different write count on a stuck location, or a different total number of pulses, when the failure is reported. A stuck toggle or fail register is visible on the next read strobe. A missed return to read mode leaves `busy` high and keeps the status byte on `dataOut` in place of FFh.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG_WR,
    S_PROG_VF,
    S_ERS_PULSE,
    S_ERS_VF,
    S_FAIL
  } eraseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic retryClr;
    logic retryInc;
    logic pulseClr;
    logic pulseInc;
    logic pwClr;
    logic pwInc;
    logic failSet;
    logic failClr;
  } dpCtl_t;

  // flags from datapath to control
  typedef struct packed {
    logic addrLast;
    logic retryLast;
    logic pulseLimit;
    logic pwLast;
    logic zeroOk;
    logic onesOk;
    logic failFlag;
  } dpFlags_t;

endpackage

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MAX_RETRY  = 3,
  parameter int MAX_PULSES = 8,
  parameter int PULSE_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              busyIn,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        memRdata,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        dataOut
);

  localparam int RW  = $clog2(MAX_RETRY + 1);
  localparam int PLW = $clog2(MAX_PULSES + 1);
  localparam int PCW = $clog2(PULSE_CYC + 1);

  logic [ADDR_W-1:0] addrCnt;
  logic [RW-1:0]     retryCnt;
  logic [PLW-1:0]    pulseCnt;
  logic [PCW-1:0]    pwCnt;
  logic              failReg;
  logic              toggleReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (ctl.addrClr) begin
      addrCnt <= '0;
    end else if (ctl.addrInc) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (ctl.retryClr) begin
      retryCnt <= '0;
    end else if (ctl.retryInc) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (ctl.pulseClr) begin
      pulseCnt <= '0;
    end else if (ctl.pulseInc) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwCnt <= '0;
    end else if (ctl.pwClr) begin
      pwCnt <= '0;
    end else if (ctl.pwInc) begin
      pwCnt <= pwCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failReg <= 1'b0;
    end else if (ctl.failClr) begin
      failReg <= 1'b0;
    end else if (ctl.failSet) begin
      failReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleReg <= 1'b0;
    end else if (rdStrobe && busyIn) begin
      toggleReg <= ~toggleReg;
    end
  end

  always_comb begin
    flags.addrLast   = &addrCnt;
    flags.retryLast  = (retryCnt == RW'(MAX_RETRY - 1));
    flags.pulseLimit = (pulseCnt == PLW'(MAX_PULSES));
    flags.pwLast     = (pwCnt == PCW'(PULSE_CYC - 1));
    flags.zeroOk     = (memRdata == 8'h00);
    flags.onesOk     = (memRdata == 8'hFF);
    flags.failFlag   = failReg;
  end

  assign memAddr  = busyIn ? addrCnt : hostAddr;
  assign memWdata = 8'h00;
  assign dataOut  = busyIn ? {1'b0, toggleReg, failReg, 5'b0_0000} : memRdata;

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busyIn) |=> (!busyIn || (dataOut[6] != $past(dataOut[6]))));

  // R9
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < RW'(MAX_RETRY));

  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PLW'(MAX_PULSES));

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startCmd,
  input  logic     abortCmd,
  input  dpFlags_t flags,
  output dpCtl_t   ctl,
  output logic     busy,
  output logic     memWe,
  output logic     erasePulse
);

  eraseState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (state != S_IDLE && abortCmd) begin
      ctl.failClr = 1'b1;
      nextState   = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (startCmd) begin
            ctl.addrClr  = 1'b1;
            ctl.retryClr = 1'b1;
            ctl.pulseClr = 1'b1;
            ctl.failClr  = 1'b1;
            nextState    = S_PROG_WR;
          end
        end
        S_PROG_WR: nextState = S_PROG_VF;
        S_PROG_VF: begin
          if (flags.zeroOk) begin
            if (flags.addrLast) begin
              ctl.addrClr = 1'b1;
              ctl.pwClr   = 1'b1;
              nextState   = S_ERS_PULSE;
            end else begin
              ctl.addrInc  = 1'b1;
              ctl.retryClr = 1'b1;
              nextState    = S_PROG_WR;
            end
          end else if (flags.retryLast) begin
            ctl.failSet = 1'b1;
            nextState   = S_FAIL;
          end else begin
            ctl.retryInc = 1'b1;
            nextState    = S_PROG_WR;
          end
        end
        S_ERS_PULSE: begin
          ctl.pwInc = 1'b1;
          if (flags.pwLast) begin
            ctl.pulseInc = 1'b1;
            ctl.addrClr  = 1'b1;
            nextState    = S_ERS_VF;
          end
        end
        S_ERS_VF: begin
          if (flags.onesOk) begin
            if (flags.addrLast) begin
              nextState = S_IDLE;
            end else begin
              ctl.addrInc = 1'b1;
            end
          end else if (flags.pulseLimit) begin
            ctl.failSet = 1'b1;
            nextState   = S_FAIL;
          end else begin
            ctl.pwClr = 1'b1;
            nextState = S_ERS_PULSE;
          end
        end
        S_FAIL: nextState = S_FAIL;
        default: nextState = S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign memWe      = (state == S_PROG_WR);
  assign erasePulse = (state == S_ERS_PULSE);

  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortCmd && busy) |=> (!busy && !memWe && !erasePulse));

  // R7
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.failFlag |-> (!memWe && !erasePulse));

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FAIL && !abortCmd) |=> (state == S_FAIL));

  // R2
  pulse_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(erasePulse) |-> ($past(state) == S_PROG_VF || $past(state) == S_ERS_VF));

endmodule

// File: rtl/chip_erase_engine.sv
module chip_erase_engine
  import erase_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MAX_RETRY  = 3,
  parameter int MAX_PULSES = 8,
  parameter int PULSE_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              abortCmd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              rdStrobe,
  output logic [7:0]        dataOut,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              erasePulse
);

  dpCtl_t   ctl;
  dpFlags_t flags;

  erase_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startCmd   (startCmd),
    .abortCmd   (abortCmd),
    .flags      (flags),
    .ctl        (ctl),
    .busy       (busy),
    .memWe      (memWe),
    .erasePulse (erasePulse)
  );

  erase_seq_dp #(
    .ADDR_W     (ADDR_W),
    .MAX_RETRY  (MAX_RETRY),
    .MAX_PULSES (MAX_PULSES),
    .PULSE_CYC  (PULSE_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .busyIn   (busy),
    .rdStrobe (rdStrobe),
    .hostAddr (hostAddr),
    .memRdata (memRdata),
    .flags    (flags),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/tb_chip_erase_engine.sv
`timescale 1ns/1ps
module tb_chip_erase_engine;

  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int MAXR = 3;
  localparam int MAXP = 8;
  localparam int PCYC = 4;

  logic clk = 0;
  logic rstN = 0;
  logic startCmd = 0, abortCmd = 0, rdStrobe = 0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0] dataOut, memWdata, memRdata;
  logic busy, memWe, erasePulse;
  logic [AW-1:0] memAddr;

  always #4 clk = ~clk;

  chip_erase_engine #(.ADDR_W(AW), .MAX_RETRY(MAXR), .MAX_PULSES(MAXP), .PULSE_CYC(PCYC)) dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .abortCmd(abortCmd),
    .hostAddr(hostAddr), .rdStrobe(rdStrobe), .dataOut(dataOut), .busy(busy),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .erasePulse(erasePulse)
  );

  // array model with optional stuck bits
  logic [7:0] mem [DEPTH];
  int needPulses = 1;
  int pulsesSeen = 0;
  int stuckAddr = -1;
  logic [7:0] stuck1 = 8'h00;
  logic [7:0] stuck0 = 8'h00;
  int writesAt [DEPTH];
  int totalWrites = 0;
  int badWrites = 0;
  int notZeroAtPulse = 0;
  int badWidth = 0;
  int widthCnt = 0;
  logic prevPulse = 0;

  assign memRdata = mem[memAddr];

  function automatic logic [7:0] forceCell(int a, logic [7:0] v);
    if (a == stuckAddr) return (v | stuck1) & ~stuck0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (memWe) begin
      totalWrites++;
      writesAt[memAddr]++;
      if (memWdata != 8'h00) badWrites++;
      mem[memAddr] = forceCell(int'(memAddr), memWdata);
    end
    if (erasePulse && !prevPulse) begin
      if (pulsesSeen == 0)
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'h00) notZeroAtPulse++;
      pulsesSeen++;
      if (pulsesSeen >= needPulses)
        for (int i = 0; i < DEPTH; i++) mem[i] = forceCell(i, 8'hFF);
    end
    if (erasePulse) widthCnt++;
    else if (prevPulse) begin
      if (widthCnt != PCYC) badWidth++;
      widthCnt = 0;
    end
    prevPulse = erasePulse;
  end

  int total = 0;
  int bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setupTest(int need, int sAddr, logic [7:0] s1, logic [7:0] s0);
    needPulses = need; stuckAddr = sAddr; stuck1 = s1; stuck0 = s0;
    pulsesSeen = 0; totalWrites = 0; badWrites = 0; notZeroAtPulse = 0; badWidth = 0;
    for (int i = 0; i < DEPTH; i++) begin
      writesAt[i] = 0;
      mem[i] = 8'h30 + 8'(i);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startCmd = 1;
    @(negedge clk); startCmd = 0;
  endtask

  task automatic pulseAbort();
    @(negedge clk); abortCmd = 1;
    @(negedge clk); abortCmd = 0;
  endtask

  task automatic doRead(output logic [7:0] v);
    @(negedge clk); rdStrobe = 1; #1 v = dataOut;
    @(negedge clk); rdStrobe = 0;
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] a, b;
    setupTest(1, -1, 0, 0);
    hostAddr = 4'd3;
    @(negedge clk); #1;
    check("R1 busy after reset", busy, 0);
    check("R1 read data", dataOut, 8'h33);
    doRead(a); doRead(b);
    check("R1 strobe no effect", {a, b}, {8'h33, 8'h33});
  endtask

  task automatic testNormal();
    logic [7:0] a, b;
    setupTest(3, -1, 0, 0);
    hostAddr = 4'd7;
    pulseStart(); #1;
    check("R2 busy after start", busy, 1);
    doRead(a); doRead(b);
    check("R3 status form", {a[7], a[5], a[4:0]}, 7'h00);
    check("R4 toggle", a[6] ^ b[6], 1);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    #1;
    check("R5 busy low at end", busy, 0);
    check("R2 only zero written", badWrites, 0);
    check("R2 zero before pulse", notZeroAtPulse, 0);
    check("R2 every cell written", totalWrites, DEPTH);
    check("R6 pulse count", pulsesSeen, 3);
    check("R6 pulse width", badWidth, 0);
    doRead(a); doRead(b);
    check("R5 read erased", {a, b}, 16'hFFFF);
  endtask

  task automatic testTimeout();
    logic [7:0] a;
    int w;
    setupTest(100, -1, 0, 0);
    hostAddr = 4'd2;
    pulseStart();
    waitCycles(700); #1;
    check("R7 busy held", busy, 1);
    check("R7 pulse total", pulsesSeen, MAXP);
    doRead(a);
    check("R7 fail status", {a[7], a[5]}, 2'b01);
    w = totalWrites;
    pulseStart();
    waitCycles(60);
    doRead(a);
    check("R8 start ignored status", {busy, a[7], a[5]}, 3'b101);
    check("R8 start ignored array", {totalWrites, pulsesSeen}, {w, MAXP});
    pulseAbort(); #1;
    check("R8 abort busy", busy, 0);
    check("R8 abort read mode", dataOut, 8'h00);
  endtask

  task automatic testProgFail();
    logic [7:0] a;
    setupTest(1, 5, 8'h04, 0);
    pulseStart();
    waitCycles(200); #1;
    check("R9 retry writes", writesAt[5], MAXR);
    check("R9 no pulse", pulsesSeen, 0);
    check("R9 next cell untouched", writesAt[6], 0);
    doRead(a);
    check("R9 fail status", {busy, a[7], a[5]}, 3'b101);
    pulseAbort();
  endtask

  task automatic testAbort();
    int w;
    setupTest(1, -1, 0, 0);
    pulseStart();
    waitCycles(6);
    pulseAbort(); #1;
    check("R10 busy drops", busy, 0);
    w = totalWrites;
    waitCycles(30);
    check("R10 no writes", totalWrites, w);
    check("R10 no pulses", pulsesSeen, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'h30 + 8'(i);
      writesAt[i] = 0;
    end
    waitCycles(3);
    rstN = 1;
    testReset();
    testNormal();
    testTimeout();
    testProgFail();
    testAbort();
    waitCycles(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule